// File: doc/BRIEF.md
# Strobed Command/Data Bus Slave

This block is the slave end of a simple point-to-point peripheral bus. A transaction opens with one command cycle: the master raises a command strobe and presents a 3-bit code and a 32-bit address. Data follows as separate words, each marked by its own data strobe. The slave serves single-word and 512-word transfers, both reads and writes, against an internal 512 x 64 word store.

Write data lands in a small buffer first. The buffer drains into the store at a limited rate, so the slave controls how fast words arrive with a ready flag that has hysteresis. The master is allowed a short skid of three words after it sees ready fall. Reads answer with a one-cycle acknowledge, then one or more strobed data words. Every transaction ends with a one-cycle completion pulse.

The slave also drives a DMA-request pair and an interrupt line from registers. These are loaded at reset, hold their values, and the master polls them.

Top module: `cmd_bus_slave`

## Requirements
- R1: A command is taken when `cmd_stb` is high in idle and `cmd_code` is one of four codes: 001 (single write), 101 (512-word write), 010 (single read) or 110 (512-word read). In these codes bit 2 selects the 512-word length and bit 1 selects a read.
- R2: The slave ignores a strobed command with any other code. It also ignores a data strobe while idle. Neither produces an acknowledge or a completion, and neither changes the store.
- R3: `rdy` is low in every cycle in which the write buffer holds 12 or more of its 16 words. After falling, `rdy` rises again only once the buffer holds 8 or fewer words. The master may send up to three words after seeing `rdy` low, and none of those words is lost.
- R4: Word addresses start at the command address modulo 512 and step by one word per transfer. After address 511 they wrap to 0.
- R5: A read raises `ack_stb` for one cycle, in the cycle after the command cycle. The first word follows in the next cycle with `rd_stb` high and the data on `rd_data`.
- R6: A 512-word read raises `rd_stb` in 512 consecutive cycles, each carrying the next word. `done` follows in the cycle after the last word.
- R7: The buffer writes at most one word into the store every 2 cycles. A write completes with a one-cycle `done` pulse in the cycle after the buffer has drained the last word of the transfer into the store.
- R8: The slave ignores a command strobe that arrives before the `done` of the current transaction has been issued. Data strobes during a read are also ignored.
- R9: `dreq` and `irq` take the values of the parameters `DREQ_INIT` and `IRQ_INIT` at reset and then stay constant.
- R10: After reset, `rdy` is 1 and `done`, `ack_stb` and `rd_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command phase strobe |
| cmd_code | input | 3 | Command code |
| cmd_addr | input | 32 | Start word address |
| dat_stb | input | 1 | Write data strobe |
| dat_in | input | 64 | Write data word |
| rdy | output | 1 | Write pacing flag |
| done | output | 1 | One-cycle completion pulse |
| ack_stb | output | 1 | Read command acknowledge |
| rd_stb | output | 1 | Read data valid strobe |
| rd_data | output | 64 | Read data word |
| dreq | output | 2 | Registered DMA request lines |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench runs a 512-word write that starts at address 500, so the addresses must wrap. Its master stalls only after three words of skid. A buffer that dropped `rdy` too late would overflow and lose words, which the read-back then exposes. Commands with the four invalid codes, and a write command injected in the middle of a burst read, must leave the store unchanged. A design that decoded the wrong bit, or took a command while busy, would produce a stray acknowledge or completion, or a corrupted word at address 7. The per-cycle model catches a completion that arrives before the buffer has drained, and a `done` that lasts more than one cycle.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RACK,
    ST_RD,
    ST_RFIN
  } cbs_state_e;

  localparam logic [2:0] CODE_WR_ONE   = 3'b001;
  localparam logic [2:0] CODE_WR_BURST = 3'b101;
  localparam logic [2:0] CODE_RD_ONE   = 3'b010;
  localparam logic [2:0] CODE_RD_BURST = 3'b110;

  function automatic logic code_ok(input logic [2:0] code);
    return (code == CODE_WR_ONE) || (code == CODE_WR_BURST) ||
           (code == CODE_RD_ONE) || (code == CODE_RD_BURST);
  endfunction

endpackage

// File: rtl/cbs_decode.sv
`timescale 1ns/1ps
module cbs_decode (
  input  logic       cmd_stb,
  input  logic [2:0] cmd_code,
  output logic       take,
  output logic       is_read,
  output logic       is_burst
);
  import cbs_pkg::*;

  always_comb begin
    take     = cmd_stb && code_ok(cmd_code);
    is_read  = cmd_code[1];
    is_burst = cmd_code[2];
  end
endmodule

// File: rtl/cbs_wbuf.sv
`timescale 1ns/1ps
module cbs_wbuf #(
  parameter int DEPTH       = 16,
  parameter int WIDTH       = 64,
  parameter int STOP_MARGIN = 4,
  parameter int RESUME_FREE = 8,
  parameter int DRAIN_GAP   = 2,
  localparam int PW    = $clog2(DEPTH),
  localparam int LVL_W = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [LVL_W-1:0] level,
  output logic             rdy
);
  localparam int GW = $clog2(DRAIN_GAP) + 1;
  localparam logic [LVL_W-1:0] STOP_LVL   = LVL_W'(DEPTH - STOP_MARGIN);
  localparam logic [LVL_W-1:0] RESUME_LVL = LVL_W'(DEPTH - RESUME_FREE);
  localparam logic [GW-1:0]    GAP_LOAD   = GW'(DRAIN_GAP - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0] lvl_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic             rdy_d;

  always_comb begin
    pop      = (level != '0) && (gap_q == '0);
    pop_data = slots[rp_q];
    wp_d     = push ? wp_q + 1'b1 : wp_q;
    rp_d     = pop  ? rp_q + 1'b1 : rp_q;
    lvl_d    = level + LVL_W'(push) - LVL_W'(pop);
    if (pop)
      gap_d = GAP_LOAD;
    else if (gap_q != '0)
      gap_d = gap_q - 1'b1;
    else
      gap_d = gap_q;
    if (lvl_d >= STOP_LVL)
      rdy_d = 1'b0;
    else if (lvl_d <= RESUME_LVL)
      rdy_d = 1'b1;
    else
      rdy_d = rdy;
  end

  always_ff @(posedge clk) begin
    if (push)
      slots[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      level <= '0;
      gap_q <= '0;
      rdy   <= 1'b1;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      level <= lvl_d;
      gap_q <= gap_d;
      rdy   <= rdy_d;
    end
  end
endmodule

// File: rtl/cbs_mem.sv
`timescale 1ns/1ps
module cbs_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (re)
      rdata <= cells[raddr];
  end
endmodule

// File: rtl/cmd_bus_slave.sv
`timescale 1ns/1ps
module cmd_bus_slave #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 64,
  parameter int          MEM_DEPTH   = 512,
  parameter int          BURST_LEN   = 512,
  parameter int          WBUF_DEPTH  = 16,
  parameter int          STOP_MARGIN = 4,
  parameter int          RESUME_FREE = 8,
  parameter int          DRAIN_GAP   = 2,
  parameter logic [1:0]  DREQ_INIT   = 2'b01,
  parameter logic        IRQ_INIT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              dat_stb,
  input  logic [DATA_W-1:0] dat_in,
  output logic              rdy,
  output logic              done,
  output logic              ack_stb,
  output logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        dreq,
  output logic              irq
);
  import cbs_pkg::*;

  localparam int MEM_AW = $clog2(MEM_DEPTH);
  localparam int CNT_W  = $clog2(BURST_LEN) + 1;
  localparam int LVL_W  = $clog2(WBUF_DEPTH) + 1;
  localparam logic [CNT_W-1:0] LEN_BURST = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(1);

  cbs_state_e        st_q, st_d;
  logic              burst_q, burst_d;
  logic [CNT_W-1:0]  rx_q, rx_d, tx_q, tx_d, total, tx_inc;
  logic [MEM_AW-1:0] wa_q, wa_d, ra_q, ra_d, base;
  logic              done_d, ack_d, rstb_d;
  logic              take, dec_read, dec_burst;
  logic              push, wb_pop, mem_re, idle_w;
  logic [DATA_W-1:0] wb_head;
  logic [LVL_W-1:0]  wb_level;
  logic              addr_hi_unused;

  assign addr_hi_unused = ^cmd_addr[ADDR_W-1:MEM_AW];
  assign base   = cmd_addr[MEM_AW-1:0];
  assign total  = burst_q ? LEN_BURST : LEN_ONE;
  assign tx_inc = tx_q + 1'b1;
  assign idle_w = (st_q == ST_IDLE);

  cbs_decode u_decode (
    .cmd_stb (cmd_stb),
    .cmd_code(cmd_code),
    .take    (take),
    .is_read (dec_read),
    .is_burst(dec_burst)
  );

  cbs_wbuf #(
    .DEPTH      (WBUF_DEPTH),
    .WIDTH      (DATA_W),
    .STOP_MARGIN(STOP_MARGIN),
    .RESUME_FREE(RESUME_FREE),
    .DRAIN_GAP  (DRAIN_GAP)
  ) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(dat_in),
    .pop      (wb_pop),
    .pop_data (wb_head),
    .level    (wb_level),
    .rdy      (rdy)
  );

  cbs_mem #(
    .DEPTH(MEM_DEPTH),
    .WIDTH(DATA_W)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wb_pop),
    .waddr(wa_q),
    .wdata(wb_head),
    .re   (mem_re),
    .raddr(ra_q),
    .rdata(rd_data)
  );

  always_comb begin
    st_d    = st_q;
    burst_d = burst_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    wa_d    = wb_pop ? wa_q + 1'b1 : wa_q;
    ra_d    = ra_q;
    done_d  = 1'b0;
    ack_d   = 1'b0;
    rstb_d  = 1'b0;
    push    = 1'b0;
    mem_re  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          burst_d = dec_burst;
          rx_d    = '0;
          tx_d    = '0;
          wa_d    = base;
          ra_d    = base;
          st_d    = dec_read ? ST_RACK : ST_WR;
        end
      end
      ST_WR: begin
        if ((rx_q == total) && (wb_level == '0)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (dat_stb && (rx_q != total)) begin
          push = 1'b1;
          rx_d = rx_q + 1'b1;
        end
      end
      ST_RACK: begin
        ack_d = 1'b1;
        st_d  = ST_RD;
      end
      ST_RD: begin
        mem_re = 1'b1;
        rstb_d = 1'b1;
        ra_d   = ra_q + 1'b1;
        tx_d   = tx_inc;
        if (tx_inc == total)
          st_d = ST_RFIN;
      end
      ST_RFIN: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      burst_q <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
      wa_q    <= '0;
      ra_q    <= '0;
      done    <= 1'b0;
      ack_stb <= 1'b0;
      rd_stb  <= 1'b0;
      dreq    <= DREQ_INIT;
      irq     <= IRQ_INIT;
    end else begin
      st_q    <= st_d;
      burst_q <= burst_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      wa_q    <= wa_d;
      ra_q    <= ra_d;
      done    <= done_d;
      ack_stb <= ack_d;
      rd_stb  <= rstb_d;
      dreq    <= dreq;
      irq     <= irq;
    end
  end
endmodule

// File: rtl/cbs_checks.sv
`timescale 1ns/1ps
module cbs_checks #(
  parameter int WBUF_DEPTH  = 16,
  parameter int STOP_MARGIN = 4,
  localparam int LVL_W = $clog2(WBUF_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stb,
  input logic [2:0]       cmd_code,
  input logic             idle_w,
  input logic             done,
  input logic             ack_stb,
  input logic             rd_stb,
  input logic             rdy,
  input logic [1:0]       dreq,
  input logic             irq,
  input logic [LVL_W-1:0] wb_level
);
  import cbs_pkg::*;

  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_data_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> rd_stb);

  a_r5_ack_not_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_stb && rd_stb));

  a_r2_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && cmd_stb && !code_ok(cmd_code)) |=> (idle_w && !ack_stb && !done));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wb_level <= LVL_W'(WBUF_DEPTH));

  a_r3_ready_low_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_level >= LVL_W'(WBUF_DEPTH - STOP_MARGIN)) |-> !rdy);

  a_r9_static_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dreq) && $stable(irq));
endmodule

bind cmd_bus_slave cbs_checks #(
  .WBUF_DEPTH (WBUF_DEPTH),
  .STOP_MARGIN(STOP_MARGIN)
) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_stb (cmd_stb),
  .cmd_code(cmd_code),
  .idle_w  (idle_w),
  .done    (done),
  .ack_stb (ack_stb),
  .rd_stb  (rd_stb),
  .rdy     (rdy),
  .dreq    (dreq),
  .irq     (irq),
  .wb_level(wb_level)
);

// File: tb/test_cmd_bus_slave.sv
`timescale 1ns/1ps
module test_cmd_bus_slave;
  localparam int         DEPTH  = 16;
  localparam int         BLEN   = 512;
  localparam logic [1:0] P_DREQ = 2'b10;
  localparam logic       P_IRQ  = 1'b1;
  localparam logic [63:0] PAT   = 64'hA5A5_0000_1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [31:0] cmd_addr = '0;
  logic        dat_stb = 1'b0;
  logic [63:0] dat_in = '0;
  logic        rdy, done, ack_stb, rd_stb, irq;
  logic [63:0] rd_data;
  logic [1:0]  dreq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cmd_bus_slave #(.DREQ_INIT(P_DREQ), .IRQ_INIT(P_IRQ)) i_cmd_bus_slave (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .dat_stb(dat_stb), .dat_in(dat_in), .rdy(rdy),
    .done(done), .ack_stb(ack_stb), .rd_stb(rd_stb), .rd_data(rd_data),
    .dreq(dreq), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_mem [512];
  logic [63:0] m_q [$];
  int  m_st, m_total, m_rx, m_tx, m_wa, m_ra, m_gap;
  bit  e_rdy, e_done, e_ack, e_rstb;
  logic [63:0] e_rdata;
  bit  saw_rdy_low;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_st = 0; m_total = 1; m_rx = 0; m_tx = 0; m_wa = 0; m_ra = 0; m_gap = 0;
      e_rdy = 1; e_done = 0; e_ack = 0; e_rstb = 0; e_rdata = '0;
    end else begin
      int  sz0;
      bit  do_pop;
      sz0 = m_q.size();
      do_pop = (sz0 > 0) && (m_gap == 0);
      e_done = 0; e_ack = 0; e_rstb = 0;
      case (m_st)
        0: if (cmd_stb && (cmd_code == 3'b001 || cmd_code == 3'b101 ||
                           cmd_code == 3'b010 || cmd_code == 3'b110)) begin
             m_total = cmd_code[2] ? BLEN : 1;
             m_rx = 0; m_tx = 0;
             m_wa = int'(cmd_addr[8:0]); m_ra = int'(cmd_addr[8:0]);
             m_st = cmd_code[1] ? 2 : 1;
           end
        1: if (m_rx == m_total && sz0 == 0) begin
             e_done = 1; m_st = 0;
           end else if (dat_stb && m_rx < m_total) begin
             m_q.push_back(dat_in); m_rx++;
           end
        2: begin e_ack = 1; m_st = 3; end
        3: begin
             e_rstb = 1; e_rdata = m_mem[m_ra];
             m_ra = (m_ra + 1) % 512; m_tx++;
             if (m_tx == m_total) m_st = 4;
           end
        default: begin e_done = 1; m_st = 0; end
      endcase
      if (do_pop) begin
        m_mem[m_wa] = m_q.pop_front();
        m_wa = (m_wa + 1) % 512;
        m_gap = 1;
      end else if (m_gap > 0) begin
        m_gap--;
      end
      if (m_q.size() >= DEPTH - 4) e_rdy = 0;
      else if (DEPTH - m_q.size() >= 8) e_rdy = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rdy) saw_rdy_low = 1;
      chk(rdy == e_rdy, "R3", "rdy vs model", 64'(rdy), 64'(e_rdy));
      chk(done == e_done, "R7", "done vs model", 64'(done), 64'(e_done));
      chk(ack_stb == e_ack, "R5", "ack_stb vs model", 64'(ack_stb), 64'(e_ack));
      chk(rd_stb == e_rstb, "R6", "rd_stb vs model", 64'(rd_stb), 64'(e_rstb));
      if (e_rstb)
        chk(rd_data == e_rdata, "R4", "rd_data vs model", rd_data, e_rdata);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- master tasks ----------------
  task automatic put_cmd(input logic [2:0] code, input logic [31:0] a);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_code = code; cmd_addr = a;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic wr_one(input logic [31:0] a, input logic [63:0] d);
    put_cmd(3'b001, a);
    @(negedge clk);
    cmd_stb = 1'b0; cmd_code = '0; dat_stb = 1'b1; dat_in = d;
    @(negedge clk);
    dat_stb = 1'b0; dat_in = '0;
    wait_done();
  endtask

  task automatic rd_one(input logic [31:0] a, output logic [63:0] d);
    d = '0;
    put_cmd(3'b010, a);
    @(negedge clk);
    cmd_stb = 1'b0; cmd_code = '0;
    while (!done) begin
      if (rd_stb) d = rd_data;
      @(negedge clk);
    end
  endtask

  task automatic wr_burst(input logic [31:0] a, input logic [63:0] start);
    int sent = 0;
    int low_cnt = 0;
    put_cmd(3'b101, a);
    @(negedge clk);
    cmd_stb = 1'b0; cmd_code = '0;
    @(negedge clk);
    while (sent < BLEN) begin
      @(negedge clk);
      if (!rdy) low_cnt++; else low_cnt = 0;
      if (low_cnt < 4) begin
        dat_stb = 1'b1; dat_in = start + 64'(sent); sent++;
      end else begin
        dat_stb = 1'b0; dat_in = '0;
      end
    end
    @(negedge clk);
    dat_stb = 1'b0; dat_in = '0;
    wait_done();
  endtask

  task automatic rd_burst(input logic [31:0] a, input bit inject,
                          output int words, output logic [63:0] first);
    int k = 0;
    words = 0; first = '0;
    put_cmd(3'b110, a);
    @(negedge clk);
    cmd_stb = 1'b0; cmd_code = '0;
    while (!done) begin
      if (rd_stb) begin
        if (words == 0) first = rd_data;
        words++;
      end
      k++;
      if (inject && k == 20) begin
        cmd_stb = 1'b1; cmd_code = 3'b001; cmd_addr = 32'd7;
      end else if (inject && k == 21) begin
        cmd_stb = 1'b0; cmd_code = '0; dat_stb = 1'b1; dat_in = 64'hDEAD;
      end else begin
        cmd_stb = 1'b0; dat_stb = 1'b0;
      end
      @(negedge clk);
    end
    cmd_stb = 1'b0; dat_stb = 1'b0;
  endtask

  initial begin
    logic [63:0] got;
    logic [63:0] first;
    int words;
    int stray;
    saw_rdy_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R9 static outputs
    chk(rdy == 1'b1, "R10", "rdy after reset", 64'(rdy), 64'd1);
    chk(done == 1'b0 && ack_stb == 1'b0 && rd_stb == 1'b0, "R10", "strobes after reset",
        64'({done, ack_stb, rd_stb}), 64'd0);
    chk(dreq == P_DREQ, "R9", "dreq after reset", 64'(dreq), 64'(P_DREQ));
    chk(irq == P_IRQ, "R9", "irq after reset", 64'(irq), 64'(P_IRQ));

    // R1 single write / single read
    wr_one(32'h0000_0005, 64'h1234_5678_9ABC_DEF0);
    rd_one(32'h0000_0005, got);
    chk(got == 64'h1234_5678_9ABC_DEF0, "R1", "single read-back", got, 64'h1234_5678_9ABC_DEF0);
    wr_one(32'hFFFF_FE05, 64'h0BAD_F00D_0000_0001);
    rd_one(32'h0000_0005, got);
    chk(got == 64'h0BAD_F00D_0000_0001, "R4", "address modulo 512", got, 64'h0BAD_F00D_0000_0001);

    // R2 invalid codes, each followed by a data strobe
    stray = 0;
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2 || c == 5 || c == 6) continue;
      put_cmd(3'(c), 32'd5);
      @(negedge clk);
      cmd_stb = 1'b0; dat_stb = 1'b1; dat_in = 64'hFFFF;
      @(negedge clk);
      dat_stb = 1'b0;
      repeat (4) begin
        if (ack_stb || done) stray++;
        @(negedge clk);
      end
    end
    chk(stray == 0, "R2", "ack/done after bad code", 64'(stray), 64'd0);
    rd_one(32'd5, got);
    chk(got == 64'h0BAD_F00D_0000_0001, "R2", "store unchanged", got, 64'h0BAD_F00D_0000_0001);

    // R3 / R4 / R7 burst write wrapping from 500
    wr_burst(32'd500, PAT);
    chk(saw_rdy_low == 1, "R3", "ready dropped during burst", 64'(saw_rdy_low), 64'd1);
    rd_one(32'd3, got);
    chk(got == PAT + 64'd15, "R4", "wrapped word at 3", got, PAT + 64'd15);
    rd_one(32'd499, got);
    chk(got == PAT + 64'd511, "R3", "last skid-paced word", got, PAT + 64'd511);

    // R6 / R8 burst read with an injected command
    rd_burst(32'd500, 1'b1, words, first);
    chk(words == BLEN, "R6", "burst word count", 64'(words), 64'(BLEN));
    chk(first == PAT, "R6", "first burst word", first, PAT);
    rd_one(32'd7, got);
    chk(got == PAT + 64'd19, "R8", "busy command ignored", got, PAT + 64'd19);

    chk(dreq == P_DREQ && irq == P_IRQ, "R9", "static outputs at end",
        64'({dreq, irq}), 64'({P_DREQ, P_IRQ}));
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule